// File: doc/BRIEF.md
# Dual-Pixel Raster Timing Generator

This block produces the scan timing for a 1600 by 1200 panel whose link carries two horizontally adjacent pixels on every clock: an even column and the odd column to its right. A horizontal counter runs in clocks, not pixels, so one count covers a pixel pair. A vertical counter advances once per line. From these two counts the block drives a horizontal sync, a vertical sync, a display-enable strobe, and the even column, odd column and line indices that a pixel source uses as its read address.

Each line is laid out as the active span, then the front porch, then the sync pulse, then the back porch. A frame follows the same order in lines. Every span width is a parameter. The defaults give the 60 Hz mode: 800 active clocks plus 32, 96 and 152 clocks of blanking, for 1080 clocks per line. Vertically, 1200 active lines are followed by 1, 3 and 46 lines of blanking, for 1250 lines per frame.

Two polarity pins select, for each sync output, whether it pulses high or low. The block samples them once, on the first clock after reset, and holds that choice for the rest of the run.

Top module: `dp_raster_gen`

## Requirements
- R1: On the first clock edge after reset is released, the outputs show the first active pixel pair: de_o=1, col_even_o=0, col_odd_o=1, line_o=0.
- R2: Every line lasts exactly H_ACT+H_FP+H_SYNC+H_BP clocks. Clock position h runs from 0 to that total minus 1, and de_o is high only for h < H_ACT on an active line.
- R3: The horizontal sync is active exactly for clock positions h with H_ACT+H_FP <= h < H_ACT+H_FP+H_SYNC. It is never active while de_o is high.
- R4: Every frame lasts exactly V_ACT+V_FP+V_SYNC+V_BP lines. The vertical sync is active for every clock of lines v with V_ACT+V_FP <= v < V_ACT+V_FP+V_SYNC. The line count changes only at the end of a line.
- R5: de_o stays low on every line v >= V_ACT.
- R6: While de_o is high, col_even_o=2h, col_odd_o=2h+1 and line_o=v. While de_o is low, all three are 0.
- R7: A polarity value of 1 makes that sync output 1 while active and 0 while inactive. A value of 0 inverts it.
- R8: hs_pos_i and vs_pos_i are sampled on the first clock edge after reset release. Any later change has no effect on hsync_o or vsync_o until the next reset.
- R9: While reset is asserted, all outputs are 0. With positive vertical polarity, the first vertical sync after reset is therefore a high pulse starting from a low level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-pair clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hs_pos_i | input | 1 | Horizontal sync polarity, 1 = active high |
| vs_pos_i | input | 1 | Vertical sync polarity, 1 = active high |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display enable, high while a pixel pair is valid |
| col_even_o | output | CW (11 by default) | Column index of the even pixel |
| col_odd_o | output | CW (11 by default) | Column index of the odd pixel |
| line_o | output | LW (11 by default) | Line index |

## Verification
All outputs sit one register behind the counters. After clock edge k following reset release, every output therefore describes raster position k-1: clock k-1 modulo the line total, on line (k-1)/line-total modulo the frame total. The bench counts edges from reset release and samples on the falling edge that follows each rising edge. It compares every output in every cycle against that position, with the polarity that was present at edge 1. Polarity pins are toggled only after the edge-1 sample, so a change that is wrongly honoured shows up on the very next sample.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Bit width needed to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cw(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Decoded raster flags for one position.
  typedef struct packed {
    logic de;
    logic hs_act;
    logic vs_act;
  } dpr_flags_t;

endpackage

// File: rtl/dpr_axis_cnt.sv
module dpr_axis_cnt #(
  parameter int unsigned ACT  = 800,
  parameter int unsigned FP   = 32,
  parameter int unsigned SYNC = 96,
  parameter int unsigned BP   = 152,
  parameter int unsigned W    = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] count_o,
  output logic         wrap_o,
  output logic         act_o,
  output logic         sync_o
);

  localparam int unsigned TOTAL = ACT + FP + SYNC + BP;
  localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
  localparam logic [W-1:0] ACT_END = W'(ACT);
  localparam logic [W-1:0] SYNC_LO = W'(ACT + FP);
  localparam logic [W-1:0] SYNC_HI = W'(ACT + FP + SYNC);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (en) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign wrap_o  = en && at_last;
  assign act_o   = (cnt_q < ACT_END);
  assign sync_o  = (cnt_q >= SYNC_LO) && (cnt_q < SYNC_HI);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && at_last) |=> (cnt_q == '0));

  // R4
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q));

endmodule

// File: rtl/dpr_pol_hold.sv
module dpr_pol_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_pos_i,
  input  logic vs_pos_i,
  output logic hpol_o,
  output logic vpol_o
);

  logic armed_q, armed_d;
  logic hpol_q, hpol_d;
  logic vpol_q, vpol_d;

  always_comb begin
    armed_d = 1'b1;
    hpol_d  = armed_q ? hpol_q : hs_pos_i;
    vpol_d  = armed_q ? vpol_q : vs_pos_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hpol_q  <= 1'b1;
      vpol_q  <= 1'b1;
    end else begin
      armed_q <= armed_d;
      hpol_q  <= hpol_d;
      vpol_q  <= vpol_d;
    end
  end

  // Before the capture, the pins themselves steer the output stage.
  assign hpol_o = armed_q ? hpol_q : hs_pos_i;
  assign vpol_o = armed_q ? vpol_q : vs_pos_i;

  // R8
  pol_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ($stable(hpol_q) && $stable(vpol_q)));

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
  parameter int unsigned HW    = 11,
  parameter int unsigned VW    = 11,
  parameter int unsigned CW    = 11,
  parameter int unsigned LW    = 11,
  parameter int unsigned V_ACT = 1200
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dpr_pkg::dpr_flags_t flags_i,
  input  logic                hpol_i,
  input  logic                vpol_i,
  input  logic [HW-1:0]       h_i,
  input  logic [VW-1:0]       v_i,
  output logic                hsync_o,
  output logic                vsync_o,
  output logic                de_o,
  output logic [CW-1:0]       col_even_o,
  output logic [CW-1:0]       col_odd_o,
  output logic [LW-1:0]       line_o
);

  localparam logic [LW:0] LINE_LIM = (LW+1)'(V_ACT);

  logic          hs_d, vs_d, de_d;
  logic [CW-1:0] ce_d, co_d;
  logic [LW-1:0] ln_d;

  always_comb begin
    de_d = flags_i.de;
    hs_d = ~(flags_i.hs_act ^ hpol_i);
    vs_d = ~(flags_i.vs_act ^ vpol_i);
    ce_d = '0;
    co_d = '0;
    ln_d = '0;
    if (flags_i.de) begin
      ce_d = CW'(h_i) << 1;
      co_d = (CW'(h_i) << 1) | CW'(1);
      ln_d = LW'(v_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      de_o       <= 1'b0;
      col_even_o <= '0;
      col_odd_o  <= '0;
      line_o     <= '0;
    end else begin
      hsync_o    <= hs_d;
      vsync_o    <= vs_d;
      de_o       <= de_d;
      col_even_o <= ce_d;
      col_odd_o  <= co_d;
      line_o     <= ln_d;
    end
  end

  // R3
  de_sync_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_i.de |-> !flags_i.hs_act);

  // R5
  de_line_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> ({1'b0, line_o} < LINE_LIM));

endmodule

// File: rtl/dp_raster_gen.sv
module dp_raster_gen #(
  parameter int unsigned H_ACT  = 800,
  parameter int unsigned H_FP   = 32,
  parameter int unsigned H_SYNC = 96,
  parameter int unsigned H_BP   = 152,
  parameter int unsigned V_ACT  = 1200,
  parameter int unsigned V_FP   = 1,
  parameter int unsigned V_SYNC = 3,
  parameter int unsigned V_BP   = 46,
  localparam int unsigned CW    = dpr_pkg::cw(2 * H_ACT),
  localparam int unsigned LW    = dpr_pkg::cw(V_ACT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_pos_i,
  input  logic          vs_pos_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] col_even_o,
  output logic [CW-1:0] col_odd_o,
  output logic [LW-1:0] line_o
);

  localparam int unsigned HT = H_ACT + H_FP + H_SYNC + H_BP;
  localparam int unsigned VT = V_ACT + V_FP + V_SYNC + V_BP;
  localparam int unsigned HW = dpr_pkg::cw(HT + 1);
  localparam int unsigned VW = dpr_pkg::cw(VT + 1);

  logic          h_en, v_en;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_wrap, v_wrap;
  logic          h_act, v_act, h_sync, v_sync;
  logic          hpol, vpol;
  dpr_pkg::dpr_flags_t flags;

  assign h_en = 1'b1;
  assign v_en = h_wrap;

  dpr_axis_cnt #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP), .W(HW)) u_hcnt (
    .clk(clk), .rst_n(rst_n), .en(h_en),
    .count_o(h_cnt), .wrap_o(h_wrap), .act_o(h_act), .sync_o(h_sync)
  );

  dpr_axis_cnt #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP), .W(VW)) u_vcnt (
    .clk(clk), .rst_n(rst_n), .en(v_en),
    .count_o(v_cnt), .wrap_o(v_wrap), .act_o(v_act), .sync_o(v_sync)
  );

  dpr_pol_hold u_pol (
    .clk(clk), .rst_n(rst_n), .hs_pos_i(hs_pos_i), .vs_pos_i(vs_pos_i),
    .hpol_o(hpol), .vpol_o(vpol)
  );

  always_comb begin
    flags.de     = h_act && v_act;
    flags.hs_act = h_sync;
    flags.vs_act = v_sync;
  end

  dpr_out_stage #(.HW(HW), .VW(VW), .CW(CW), .LW(LW), .V_ACT(V_ACT)) u_out (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .hpol_i(hpol), .vpol_i(vpol),
    .h_i(h_cnt), .v_i(v_cnt),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
    .col_even_o(col_even_o), .col_odd_o(col_odd_o), .line_o(line_o)
  );

  // R4
  v_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(v_cnt) |-> $past(h_wrap));

  // R4
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |=> (v_cnt == '0 && h_cnt == '0));

endmodule

// File: tb/tb_dp_raster_gen.sv
`timescale 1ns/1ps
module tb_dp_raster_gen;

  localparam int HA = 6, HF = 2, HS = 3, HB = 2;
  localparam int VA = 4, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int FR = HT * VT;
  localparam int CW = dpr_pkg::cw(2 * HA);
  localparam int LW = dpr_pkg::cw(VA);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_pos = 1'b1;
  logic vs_pos = 1'b1;
  logic hsync, vsync, de;
  logic [CW-1:0] col_e, col_o;
  logic [LW-1:0] line;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dp_raster_gen #(
    .H_ACT(HA), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hs_pos_i(hs_pos), .vs_pos_i(vs_pos),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .col_even_o(col_e), .col_odd_o(col_o), .line_o(line)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_de(input int p);
    int h = p % HT;
    int v = (p / HT) % VT;
    return (h < HA && v < VA) ? 1 : 0;
  endfunction

  function automatic int exp_hs(input int p, input bit pol);
    int h = p % HT;
    bit a = (h >= HA + HF) && (h < HA + HF + HS);
    return (a == pol) ? 1 : 0;
  endfunction

  function automatic int exp_vs(input int p, input bit pol);
    int v = (p / HT) % VT;
    bit a = (v >= VA + VF) && (v < VA + VF + VS);
    return (a == pol) ? 1 : 0;
  endfunction

  task automatic run(input int ncyc, input bit hp, input bit vp, input bit tog);
    @(negedge clk);
    rst_n  = 1'b0;
    hs_pos = hp;
    vs_pos = vp;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 reset hsync", hsync, 0);
      chk("R9 reset vsync", vsync, 0);
      chk("R9 reset de", de, 0);
      chk("R9 reset col", int'(col_e) + int'(col_o) + int'(line), 0);
    end
    rst_n = 1'b1;
    for (int k = 1; k <= ncyc; k++) begin
      int p = k - 1;
      int h = p % HT;
      int v = (p / HT) % VT;
      int d;
      @(negedge clk);
      d = exp_de(p);
      if (k == 1) begin
        chk("R1 first de", de, 1);
        chk("R1 first col_even", col_e, 0);
        chk("R1 first col_odd", col_o, 1);
        chk("R1 first line", line, 0);
      end
      if (vp && p == (VA + VF) * HT) chk("R9 first vsync high", vsync, 1);
      chk(v >= VA ? "R5 de blank line" : "R2 de", de, d);
      chk("R3 R7 R8 hsync", hsync, exp_hs(p, hp));
      chk("R4 R7 R8 vsync", vsync, exp_vs(p, vp));
      chk("R6 col_even", col_e, d ? 2 * h : 0);
      chk("R6 col_odd", col_o, d ? 2 * h + 1 : 0);
      chk("R6 line", line, d ? v : 0);
      if (tog) begin
        hs_pos = 1'($urandom);
        vs_pos = 1'($urandom);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h0C0FFEE5));
    run(3 * FR, 1'b1, 1'b1, 1'b0);
    run(2 * FR + 7, 1'b0, 1'b1, 1'b1);
    run(FR + 40, 1'b1, 1'b0, 1'b1);
    run(2 * FR, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++)
      run(FR + int'($urandom % FR), 1'($urandom), 1'($urandom), 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule